// File: doc/BRIEF.md
# Sizable Memory Window Base Register

This block is the target-side base register for one memory window in a device's configuration space. The window has a fixed power-of-two size. Host enumeration software discovers that size with the usual probe: it saves the register, writes all ones, reads back a mask, and then restores the old value or writes a newly assigned base. Only the address bits at or above log2 of the window size are stored. Every bit below them reads as zero. The lowest nibble carries read-only attributes: memory space, 32-bit decode and an optional prefetchable flag.

The block also holds the memory-enable bit of the command register. It drives a combinational hit output that claims an inbound memory address falling inside the programmed window. Configuration writes arrive on a dword-addressed port with byte enables and take effect at the clock edge. Reads are combinational from the same dword address.

Top module: `bar_window_top`

## Requirements
- R1: After reset the base register (dword 5) reads 0x00000008 with the default parameters, the command register (dword 1) reads 0x00000000, and hit_o is 0.
- R2: Writing 0xFFFFFFFF to the base register with all byte enables makes it read back the size mask 0xFFF80008 for the default 512 KB prefetchable window. Clearing the low 4 bits, inverting and adding one gives 0x00080000. A later base write, such as 0xC0000000, reads back as 0xC0000008.
- R3: Bits 3:0 of the base register always read {PREFETCH, 2'b00, 1'b0}, and bits between 4 and SIZE_LOG2-1 always read zero, whatever is written.
- R4: Writing a previously read value back to the base register returns it to exactly that value.
- R5: Byte enable bit k gates bits 8k+7:8k of a configuration write. Bytes whose enable is low keep their previous contents.
- R6: In the command register only bit 1 (memory enable) is writable. All other bits read zero.
- R7: hit_o is 1 exactly when in_valid_i is 1, memory enable is 1, and in_addr_i[31:SIZE_LOG2] equals the stored base bits.
- R8: A write to any dword other than 1 and 5 changes nothing, and such dwords read zero.
- R9: A configuration write is visible on cfg_rdata_o only after the clock edge that accepts it. Before that edge the old value is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_dw_i | input | 6 | Dword index into configuration space |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_be_i | input | 4 | Byte enables for a write |
| cfg_rdata_o | output | 32 | Combinational read data for cfg_dw_i |
| in_valid_i | input | 1 | Inbound memory access present |
| in_addr_i | input | 32 | Inbound memory address |
| hit_o | output | 1 | Inbound access claimed by this window |

## Verification
The following properties are checked on every cycle:
- The attribute nibble and the hardwired-zero span of the base register are held fixed.
- The command register never shows any bit other than memory enable.
- hit_o never rises without both memory enable and a valid access.
- A write to an unrelated dword leaves the stored base untouched.
- A full all-ones write fills every stored base bit.

Only the bench scenarios can show the following:
- The numeric size mask and the save/restore round trip.
- Byte-lane merging.
- The exact window edges that separate a hit from a miss.
- The one-edge delay between a write and its read-back.

// File: rtl/bar_pkg.sv
package bar_pkg;
  typedef logic [31:0] dword_t;
  typedef enum logic [1:0] {SEL_NONE, SEL_CMD, SEL_BAR} cfg_sel_e;

  // low attribute nibble: memory space, 32-bit decode, optional prefetch
  function automatic logic [3:0] bar_attr(input bit prefetch);
    return {prefetch, 2'b00, 1'b0};
  endfunction
endpackage

// File: rtl/bar_cfg_decode.sv
module bar_cfg_decode
  import bar_pkg::*;
#(
  parameter int unsigned BAR_DW = 5,
  parameter int unsigned CMD_DW = 1
) (
  input  logic [5:0] dw_i,
  output cfg_sel_e   sel_o
);
  localparam logic [5:0] BarIdx = 6'(BAR_DW);
  localparam logic [5:0] CmdIdx = 6'(CMD_DW);

  always_comb begin
    if (dw_i == BarIdx)      sel_o = SEL_BAR;
    else if (dw_i == CmdIdx) sel_o = SEL_CMD;
    else                     sel_o = SEL_NONE;
  end
endmodule

// File: rtl/bar_base_reg.sv
module bar_base_reg #(
  parameter int unsigned SIZE_LOG2 = 19
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [31:0]           wdata_i,
  input  logic [3:0]            be_i,
  output logic [31:SIZE_LOG2]   base_o
);
  logic unused_low;
  assign unused_low = ^wdata_i[SIZE_LOG2-1:0];

  // one flop per writable bit, gated by its byte lane
  for (genvar i = SIZE_LOG2; i < 32; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 base_o[i] <= 1'b0;
      else if (we_i && be_i[i/8])  base_o[i] <= wdata_i[i];
    end
  end
endmodule

// File: rtl/bar_cmd_reg.sv
module bar_cmd_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic be0_i,
  input  logic wbit_i,
  output logic mem_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             mem_en_o <= 1'b0;
    else if (we_i && be0_i)  mem_en_o <= wbit_i;
  end
endmodule

// File: rtl/bar_addr_match.sv
module bar_addr_match #(
  parameter int unsigned SIZE_LOG2 = 19
) (
  input  logic                 valid_i,
  input  logic                 mem_en_i,
  input  logic [31:SIZE_LOG2]  addr_hi_i,
  input  logic [31:SIZE_LOG2]  base_i,
  output logic                 hit_o
);
  assign hit_o = valid_i && mem_en_i && (addr_hi_i == base_i);
endmodule

// File: rtl/bar_window_top.sv
module bar_window_top
  import bar_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 19,
  parameter bit          PREFETCH  = 1'b1,
  parameter int unsigned BAR_DW    = 5,
  parameter int unsigned CMD_DW    = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [5:0]  cfg_dw_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic [3:0]  cfg_be_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        in_valid_i,
  input  logic [31:0] in_addr_i,
  output logic        hit_o
);
  localparam int unsigned ZeroW = SIZE_LOG2 - 4;
  localparam logic [3:0]  Attr  = bar_attr(PREFETCH);

  cfg_sel_e              sel;
  logic [31:SIZE_LOG2]   base_q;
  logic                  mem_en;
  logic                  unused_addr;

  assign unused_addr = ^in_addr_i[SIZE_LOG2-1:0];

  bar_cfg_decode #(.BAR_DW(BAR_DW), .CMD_DW(CMD_DW)) u_dec (
    .dw_i (cfg_dw_i),
    .sel_o(sel)
  );

  bar_base_reg #(.SIZE_LOG2(SIZE_LOG2)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i && (sel == SEL_BAR)),
    .wdata_i(cfg_wdata_i),
    .be_i   (cfg_be_i),
    .base_o (base_q)
  );

  bar_cmd_reg u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i && (sel == SEL_CMD)),
    .be0_i   (cfg_be_i[0]),
    .wbit_i  (cfg_wdata_i[1]),
    .mem_en_o(mem_en)
  );

  bar_addr_match #(.SIZE_LOG2(SIZE_LOG2)) u_match (
    .valid_i  (in_valid_i),
    .mem_en_i (mem_en),
    .addr_hi_i(in_addr_i[31:SIZE_LOG2]),
    .base_i   (base_q),
    .hit_o    (hit_o)
  );

  always_comb begin
    unique case (sel)
      SEL_BAR: cfg_rdata_o = {base_q, {ZeroW{1'b0}}, Attr};
      SEL_CMD: cfg_rdata_o = {30'd0, mem_en, 1'b0};
      default: cfg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/bar_window_chk.sv
module bar_window_chk #(
  parameter int unsigned SIZE_LOG2 = 19,
  parameter bit          PREFETCH  = 1'b1,
  parameter int unsigned BAR_DW    = 5,
  parameter int unsigned CMD_DW    = 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cfg_we_i,
  input logic [5:0]          cfg_dw_i,
  input logic [31:0]         cfg_wdata_i,
  input logic [3:0]          cfg_be_i,
  input logic [31:0]         cfg_rdata_o,
  input logic                in_valid_i,
  input logic                hit_o,
  input logic                mem_en,
  input logic [31:SIZE_LOG2] base_q
);
  localparam logic [5:0] BarIdx = 6'(BAR_DW);
  localparam logic [5:0] CmdIdx = 6'(CMD_DW);

  // R3
  attr_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_dw_i == BarIdx) |-> (cfg_rdata_o[3:0] == {PREFETCH, 3'b000}));

  // R3
  low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_dw_i == BarIdx) |-> (cfg_rdata_o[SIZE_LOG2-1:4] == '0));

  // R6
  cmd_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_dw_i == CmdIdx) |-> ((cfg_rdata_o & 32'hFFFF_FFFD) == 32'h0));

  // R7
  hit_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (mem_en && in_valid_i));

  // R8
  other_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_dw_i != BarIdx) |=> $stable(base_q));

  // R2
  all_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_dw_i == BarIdx && cfg_be_i == 4'hF && cfg_wdata_i == 32'hFFFF_FFFF)
    |=> (base_q == '1));
endmodule

bind bar_window_top bar_window_chk #(
  .SIZE_LOG2(SIZE_LOG2), .PREFETCH(PREFETCH), .BAR_DW(BAR_DW), .CMD_DW(CMD_DW)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_dw_i(cfg_dw_i),
  .cfg_wdata_i(cfg_wdata_i), .cfg_be_i(cfg_be_i), .cfg_rdata_o(cfg_rdata_o),
  .in_valid_i(in_valid_i), .hit_o(hit_o), .mem_en(mem_en), .base_q(base_q)
);

// File: tb/bar_window_top_tb_top.sv
module bar_window_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  dw = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic [31:0] rdata;
  logic        in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic        hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bar_window_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_dw_i(dw),
    .cfg_wdata_i(wdata), .cfg_be_i(be), .cfg_rdata_o(rdata),
    .in_valid_i(in_valid), .in_addr_i(in_addr), .hit_o(hit)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  a;
    logic [31:0] d;
    logic [3:0]  be;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd5, 32'h0,         4'h0, 32'h0000_0008, 4'd1}, // R1 base after reset
    '{1'b0, 6'd1, 32'h0,         4'h0, 32'h0000_0000, 4'd1}, // R1 cmd after reset
    '{1'b1, 6'd5, 32'hFFFF_FFFF, 4'hF, 32'h0,         4'd2},
    '{1'b0, 6'd5, 32'h0,         4'h0, 32'hFFF8_0008, 4'd2}, // R2 size mask
    '{1'b1, 6'd5, 32'h0000_0000, 4'hF, 32'h0,         4'd4},
    '{1'b0, 6'd5, 32'h0,         4'h0, 32'h0000_0008, 4'd4}, // R4 restored
    '{1'b1, 6'd5, 32'hC000_0000, 4'hF, 32'h0,         4'd2},
    '{1'b0, 6'd5, 32'h0,         4'h0, 32'hC000_0008, 4'd2}, // R2 assigned base
    '{1'b1, 6'd5, 32'h2007_FFFF, 4'hF, 32'h0,         4'd3},
    '{1'b0, 6'd5, 32'h0,         4'h0, 32'h2000_0008, 4'd3}, // R3 low bits fixed
    '{1'b1, 6'd1, 32'h0000_FFFF, 4'hF, 32'h0,         4'd6},
    '{1'b0, 6'd1, 32'h0,         4'h0, 32'h0000_0002, 4'd6}, // R6 only bit 1
    '{1'b1, 6'd8, 32'hFFFF_FFFF, 4'hF, 32'h0,         4'd8},
    '{1'b0, 6'd5, 32'h0,         4'h0, 32'h2000_0008, 4'd8}, // R8 base untouched
    '{1'b0, 6'd8, 32'h0,         4'h0, 32'h0000_0000, 4'd8}, // R8 other dword zero
    '{1'b1, 6'd5, 32'hAABB_CCDD, 4'h8, 32'h0,         4'd5},
    '{1'b0, 6'd5, 32'h0,         4'h0, 32'hAA00_0008, 4'd5}, // R5 top lane only
    '{1'b1, 6'd5, 32'h11FF_0000, 4'h4, 32'h0,         4'd5},
    '{1'b0, 6'd5, 32'h0,         4'h0, 32'hAAF8_0008, 4'd5}  // R5 lane 2 only
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    we = 1'b1; dw = a; wdata = d; be = b;
    @(negedge clk);
    we = 1'b0; be = '0;
  endtask

  task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    dw = a;
    #1;
    d = rdata;
  endtask

  task automatic hit_probe(input logic v, input logic [31:0] a, input logic exp, input string tag);
    @(negedge clk);
    in_valid = v; in_addr = a;
    #1;
    check(tag, {31'd0, hit}, {31'd0, exp});
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    check("R1 hit after reset", {31'd0, hit}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) cfg_write(VECS[i].a, VECS[i].d, VECS[i].be);
      else begin
        cfg_read(VECS[i].a, r);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), r, VECS[i].exp);
      end
    end

    // R2 size arithmetic from read-back
    cfg_write(6'd5, 32'hFFFF_FFFF, 4'hF);
    cfg_read(6'd5, r);
    check("R2 computed size", ~(r & 32'hFFFF_FFF0) + 32'd1, 32'h0008_0000);

    // R9 old value seen before the accepting edge
    @(negedge clk);
    we = 1'b1; dw = 6'd5; wdata = 32'hC000_0000; be = 4'hF;
    #1;
    check("R9 before edge", rdata, 32'hFFF8_0008);
    @(negedge clk);
    we = 1'b0; be = '0;
    #1;
    check("R9 after edge", rdata, 32'hC000_0008);

    // R7 window edges, memory enable still set
    hit_probe(1'b1, 32'hC000_1234, 1'b1, "R7 inside");
    hit_probe(1'b1, 32'hC007_FFFC, 1'b1, "R7 top edge");
    hit_probe(1'b1, 32'hC008_0000, 1'b0, "R7 above");
    hit_probe(1'b1, 32'hBFFF_FFFC, 1'b0, "R7 below");
    hit_probe(1'b0, 32'hC000_1234, 1'b0, "R7 not valid");
    cfg_write(6'd1, 32'h0, 4'hF);
    hit_probe(1'b1, 32'hC000_1234, 1'b0, "R7 mem disabled");
    cfg_write(6'd1, 32'h2, 4'h1);
    hit_probe(1'b1, 32'hC000_1234, 1'b1, "R7 re-enabled");

    // R1 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 hit in reset", {31'd0, hit}, 32'd0);
    dw = 6'd5; #1;
    check("R1 base in reset", rdata, 32'h0000_0008);
    dw = 6'd1; #1;
    check("R1 cmd in reset", rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule